// File: doc/BRIEF.md
# Hit frame memory with serial readout

This block records detector hits during an acquisition window and sends them out once the window closes. Each of 64 channels supplies two discriminator bits, one per threshold. On every clock where acquisition is enabled and at least one of the 128 bits is set, the block stores one 160-bit frame. The frame holds an 8-bit header supplied at the port, the 24-bit crossing number of that clock, and the hit bits. Clocks without any hit leave no trace in memory. The memory holds 128 frames. When it is full, a flag rises and further hits are dropped.

Once acquisition is off, a readout request starts the serializer. It sends every stored frame, oldest first, on a single data line with a valid/ready handshake. One bit moves on each clock where valid and ready are both high. While valid is high and ready is low, the line holds its bit and valid stays high. A downstream consumer therefore sets the bit rate with ready, whether it runs at 5 MHz or at 1.25 MHz. At the end the block clears its store and returns to idle, ready for the next window.

Top module: `hfm_hit_memory`

## Requirements
- R1: A frame is written only on a clock where `acq_en` is high and at least one bit of `hit_thr0`/`hit_thr1` is set. Hits while `acq_en` is low are never stored.
- R2: Each frame goes out as 160 bits in this order. First the header, bit 7 first. Then the crossing number, bit 23 first. Then the threshold-0 bits of channels 0 up to 63. Then the threshold-1 bits of channels 0 up to 63.
- R3: The crossing number is 0 on the first clock that `acq_en` is high. It increases by one on each following clock with `acq_en` high. It returns to 0 whenever `acq_en` is low.
- R4: The store holds 128 frames. `mem_full` is high from the clock after the 128th write until the store is emptied by readout. Hits that arrive while it is high are discarded.
- R5: `rd_start` is accepted only when `acq_en` is low and no readout is running. Otherwise it is ignored.
- R6: A readout sends exactly the frames written, in write order, and then returns to idle. The store is then empty, so `mem_full` is low and a second request sends nothing.
- R7: A bit is transferred on each clock where `sout_valid` and `sout_ready` are both high. While `sout_valid` is high and `sout_ready` is low, `sout_valid` stays high and `sout_data` holds its value.
- R8: `sout_valid` is high for exactly 160 transfers per stored frame and only during a readout. A request with an empty store raises no valid at all.
- R9: After reset, `sout_valid` and `mem_full` are low and the store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing and readout clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_en | input | 1 | Acquisition window is open |
| hit_thr0 | input | 64 | Threshold-0 hit bit per channel |
| hit_thr1 | input | 64 | Threshold-1 hit bit per channel |
| header | input | 8 | Header value stored into each frame |
| rd_start | input | 1 | Request to stream out the store |
| sout_ready | input | 1 | Consumer accepts the current bit |
| sout_data | output | 1 | Serial frame bit |
| sout_valid | output | 1 | Serial bit is valid |
| mem_full | output | 1 | No free frame slot remains |

## Verification
The bench mixes clocks with hits and clocks without them. A design that stored empty crossings, or that numbered crossings by stored frame rather than by clock, would send crossing numbers that do not match. It fills the store past 128 entries. A design with an off-by-one full test would either raise `mem_full` one write early or overwrite the first frame, and both show up in the flag timing or the streamed data. Readout is repeated with ready always high and with two sparse ready patterns. A shifter that advanced without ready would drop or repeat bits. Requests during acquisition and requests with an empty store are also tried. Here a careless start condition would produce stray valid bits.

// File: rtl/hfm_pkg.sv
package hfm_pkg;
  typedef enum logic [1:0] {
    RD_IDLE,
    RD_LOAD,
    RD_SHIFT
  } rd_state_t;
endpackage

// File: rtl/hfm_bcid_counter.sv
module hfm_bcid_counter #(
  parameter int BCID_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_en,
  output logic [BCID_W-1:0] bcid
);
  always_ff @(posedge clk) begin
    if (!rst_n)      bcid <= '0;
    else if (acq_en) bcid <= bcid + 1'b1;
    else             bcid <= '0;
  end
endmodule

// File: rtl/hfm_frame_pack.sv
module hfm_frame_pack #(
  parameter int NCH    = 64,
  parameter int BCID_W = 24,
  parameter int HDR_W  = 8,
  parameter int FRAME_W = HDR_W + BCID_W + 2*NCH
) (
  input  logic [HDR_W-1:0]   header,
  input  logic [BCID_W-1:0]  bcid,
  input  logic [NCH-1:0]     thr0,
  input  logic [NCH-1:0]     thr1,
  output logic [FRAME_W-1:0] frame,
  output logic               any_hit
);
  // header in the top bits, then crossing number, then hit fields
  assign frame[FRAME_W-1 -: HDR_W] = header;
  assign frame[2*NCH +: BCID_W]    = bcid;

  // channel 0 sits at the most significant position of each hit field
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign frame[2*NCH-1-c] = thr0[c];
    assign frame[NCH-1-c]   = thr1[c];
  end

  assign any_hit = |{thr0, thr1};
endmodule

// File: rtl/hfm_frame_store.sv
module hfm_frame_store #(
  parameter int FRAME_W = 160,
  parameter int DEPTH   = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [FRAME_W-1:0]         wr_frame,
  input  logic                       clr,
  input  logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic [FRAME_W-1:0]         rd_frame,
  output logic [$clog2(DEPTH+1)-1:0] frame_cnt,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [FRAME_W-1:0] mem [DEPTH];
  logic               do_wr;

  assign full  = (frame_cnt == CAP);
  assign do_wr = wr_en && !full;

  always_ff @(posedge clk) begin
    if (do_wr) mem[frame_cnt[AW-1:0]] <= wr_frame;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     frame_cnt <= '0;
    else if (clr)   frame_cnt <= '0;
    else if (do_wr) frame_cnt <= frame_cnt + 1'b1;
  end

  assign rd_frame = mem[rd_addr];
endmodule

// File: rtl/hfm_serializer.sv
module hfm_serializer
  import hfm_pkg::*;
#(
  parameter int FRAME_W = 160,
  parameter int DEPTH   = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [$clog2(DEPTH+1)-1:0] frame_cnt,
  output logic [$clog2(DEPTH)-1:0]   rd_addr,
  input  logic [FRAME_W-1:0]         rd_frame,
  input  logic                       sout_ready,
  output logic                       sout_data,
  output logic                       sout_valid,
  output logic                       busy,
  output logic                       done
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int BW = $clog2(FRAME_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W-1);

  rd_state_t          state;
  logic [FRAME_W-1:0] shreg;
  logic [BW-1:0]      bitcnt;
  logic [CW-1:0]      rptr;
  logic [CW-1:0]      rptr_nx;
  logic               xfer;
  logic               frame_end;
  logic               last_frame;

  assign rptr_nx    = rptr + 1'b1;
  assign xfer       = (state == RD_SHIFT) && sout_ready;
  assign frame_end  = xfer && (bitcnt == LAST_BIT);
  assign last_frame = (rptr_nx == frame_cnt);

  assign done = (frame_end && last_frame) ||
                ((state == RD_IDLE) && start && (frame_cnt == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= RD_IDLE;
      shreg  <= '0;
      bitcnt <= '0;
      rptr   <= '0;
    end else begin
      unique case (state)
        RD_IDLE: begin
          rptr <= '0;
          if (start && frame_cnt != '0) state <= RD_LOAD;
        end
        RD_LOAD: begin
          shreg  <= rd_frame;
          bitcnt <= '0;
          state  <= RD_SHIFT;
        end
        RD_SHIFT: begin
          if (sout_ready) begin
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
            if (bitcnt == LAST_BIT) begin
              rptr  <= rptr_nx;
              state <= last_frame ? RD_IDLE : RD_LOAD;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

  assign rd_addr    = rptr[AW-1:0];
  assign sout_data  = shreg[FRAME_W-1];
  assign sout_valid = (state == RD_SHIFT);
  assign busy       = (state != RD_IDLE);
endmodule

// File: rtl/hfm_hit_memory.sv
module hfm_hit_memory #(
  parameter int NCH    = 64,
  parameter int DEPTH  = 128,
  parameter int BCID_W = 24,
  parameter int HDR_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_en,
  input  logic [NCH-1:0]   hit_thr0,
  input  logic [NCH-1:0]   hit_thr1,
  input  logic [HDR_W-1:0] header,
  input  logic             rd_start,
  input  logic             sout_ready,
  output logic             sout_data,
  output logic             sout_valid,
  output logic             mem_full
);
  localparam int FRAME_W = HDR_W + BCID_W + 2*NCH;
  localparam int AW      = $clog2(DEPTH);
  localparam int CW      = $clog2(DEPTH+1);

  logic [BCID_W-1:0]  bcid;
  logic [FRAME_W-1:0] wr_frame;
  logic [FRAME_W-1:0] rd_frame;
  logic [AW-1:0]      rd_addr;
  logic [CW-1:0]      frame_cnt;
  logic               any_hit;
  logic               busy;
  logic               done;
  logic               wr_en;
  logic               start;

  assign start = rd_start && !acq_en && !busy;
  assign wr_en = acq_en && any_hit && !busy;

  hfm_bcid_counter #(.BCID_W(BCID_W)) u_bcid (
    .clk    (clk),
    .rst_n  (rst_n),
    .acq_en (acq_en),
    .bcid   (bcid)
  );

  hfm_frame_pack #(
    .NCH(NCH), .BCID_W(BCID_W), .HDR_W(HDR_W), .FRAME_W(FRAME_W)
  ) u_pack (
    .header  (header),
    .bcid    (bcid),
    .thr0    (hit_thr0),
    .thr1    (hit_thr1),
    .frame   (wr_frame),
    .any_hit (any_hit)
  );

  hfm_frame_store #(.FRAME_W(FRAME_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_frame  (wr_frame),
    .clr       (done),
    .rd_addr   (rd_addr),
    .rd_frame  (rd_frame),
    .frame_cnt (frame_cnt),
    .full      (mem_full)
  );

  hfm_serializer #(.FRAME_W(FRAME_W), .DEPTH(DEPTH)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .frame_cnt  (frame_cnt),
    .rd_addr    (rd_addr),
    .rd_frame   (rd_frame),
    .sout_ready (sout_ready),
    .sout_data  (sout_data),
    .sout_valid (sout_valid),
    .busy       (busy),
    .done       (done)
  );
endmodule

// File: rtl/hfm_hit_memory_chk.sv
module hfm_hit_memory_chk #(
  parameter int DEPTH  = 128,
  parameter int BCID_W = 24
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       acq_en,
  input logic                       sout_ready,
  input logic                       sout_data,
  input logic                       sout_valid,
  input logic                       mem_full,
  input logic                       rd_busy,
  input logic [$clog2(DEPTH+1)-1:0] frame_cnt,
  input logic [BCID_W-1:0]          bcid
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sout_valid && !sout_ready |=> sout_valid && $stable(sout_data));

  // R3
  bcid_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_en |=> bcid == BCID_W'($past(bcid) + 1'b1));

  // R3
  bcid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_en |=> bcid == '0);

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_full && !rd_busy |=> mem_full);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt <= ($clog2(DEPTH+1))'(DEPTH));

  // R5
  start_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_en && !rd_busy |=> !rd_busy);

  // R1
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_en && !rd_busy |=> frame_cnt == $past(frame_cnt));

  // R8
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sout_valid |-> rd_busy);
endmodule

bind hfm_hit_memory hfm_hit_memory_chk #(.DEPTH(DEPTH), .BCID_W(BCID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acq_en     (acq_en),
  .sout_ready (sout_ready),
  .sout_data  (sout_data),
  .sout_valid (sout_valid),
  .mem_full   (mem_full),
  .rd_busy    (busy),
  .frame_cnt  (frame_cnt),
  .bcid       (bcid)
);

// File: tb/hfm_hit_memory_tb.sv
module hfm_hit_memory_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acq_en = 1'b0;
  logic [63:0] hit_thr0 = '0;
  logic [63:0] hit_thr1 = '0;
  logic [7:0]  header = '0;
  logic        rd_start = 1'b0;
  logic        sout_ready = 1'b0;
  logic        sout_data;
  logic        sout_valid;
  logic        mem_full;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [7:0]  exp_hdr  [128];
  logic [23:0] exp_bcid [128];
  logic [63:0] exp_t0   [128];
  logic [63:0] exp_t1   [128];
  int          exp_n = 0;

  always #4 clk = ~clk;

  hfm_hit_memory u_dut (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en),
    .hit_thr0(hit_thr0), .hit_thr1(hit_thr1), .header(header),
    .rd_start(rd_start), .sout_ready(sout_ready),
    .sout_data(sout_data), .sout_valid(sout_valid), .mem_full(mem_full)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [63:0] pat(int i, int salt);
    return {32'(i * 32'h9E37 + salt + 1), 32'(32'hC0DE0000 ^ (i << 3) ^ salt)};
  endfunction

  // mode 0: hits on every third crossing, alternating threshold use; mode 1: hits every crossing
  task automatic acquire(input int ncyc, input int mode, input logic [7:0] hdr, input int poke_start);
    int seen_valid = 0;
    header = hdr;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (sout_valid) seen_valid++;
      if (ncyc > 128 && i == 127) check(mem_full == 1'b0, "R4 full not early", mem_full, 0);
      if (ncyc > 128 && i == 128) check(mem_full == 1'b1, "R4 full after 128", mem_full, 1);
      acq_en   = 1'b1;
      rd_start = (i == poke_start);
      if (mode == 1 || (i % 3) == 0) begin
        hit_thr0 = (mode == 0 && (i % 2) == 1) ? 64'd0 : pat(i, 7);
        hit_thr1 = pat(i, 99) ^ 64'hFFFF_0000_0000_FFFF;
      end else begin
        hit_thr0 = '0;
        hit_thr1 = '0;
      end
      if ((hit_thr0 | hit_thr1) != 0 && exp_n < 128) begin
        exp_hdr[exp_n]  = hdr;
        exp_bcid[exp_n] = 24'(i);
        exp_t0[exp_n]   = hit_thr0;
        exp_t1[exp_n]   = hit_thr1;
        exp_n++;
      end
    end
    @(negedge clk);
    if (sout_valid) seen_valid++;
    acq_en = 1'b0; rd_start = 1'b0; hit_thr0 = '0; hit_thr1 = '0;
    if (poke_start >= 0) check(seen_valid == 0, "R5 start ignored in acquisition", seen_valid, 0);
  endtask

  function automatic logic exp_bit(int f, int k);
    if (k < 8)  return exp_hdr[f][7-k];
    if (k < 32) return exp_bcid[f][23-(k-8)];
    if (k < 96) return exp_t0[f][k-32];
    return exp_t1[f][k-96];
  endfunction

  function automatic logic ready_of(int mode, int cyc);
    if (mode == 0) return 1'b1;
    if (mode == 1) return (cyc % 4) == 0;
    return (cyc % 3) != 0;
  endfunction

  task automatic readout(input int rmode);
    int total = exp_n * 160;
    int idx = 0;
    int mis = 0;
    int extra = 0;
    int limit = total * 5 + 200;
    @(negedge clk);
    rd_start = 1'b1;
    for (int cyc = 0; cyc < limit && idx < total; cyc++) begin
      @(negedge clk);
      rd_start = 1'b0;
      sout_ready = ready_of(rmode, cyc);
      if (sout_valid && sout_ready) begin
        if (sout_data !== exp_bit(idx / 160, idx % 160)) mis++;
        if ((idx % 160) == 159) begin
          check(mis == 0, $sformatf("R2 R6 frame %0d bit errors", idx / 160), mis, 0);
          mis = 0;
        end
        idx++;
      end
    end
    check(idx == total, "R8 bits transferred", idx, total);
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      sout_ready = 1'b1;
      if (sout_valid) extra++;
    end
    sout_ready = 1'b0;
    check(extra == 0, "R6 idle after last frame", extra, 0);
    check(mem_full == 1'b0, "R6 store emptied", mem_full, 0);
    exp_n = 0;
  endtask

  task automatic expect_silence(input string req);
    int seen = 0;
    @(negedge clk);
    rd_start = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      rd_start = 1'b0;
      sout_ready = 1'b1;
      if (sout_valid) seen++;
    end
    sout_ready = 1'b0;
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(sout_valid == 1'b0, "R9 valid low after reset", sout_valid, 0);
    check(mem_full == 1'b0, "R9 full low after reset", mem_full, 0);
    expect_silence("R9 R8 empty store after reset");

    // R1 hits with acquisition off are not stored
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      hit_thr0 = pat(i, 3); hit_thr1 = pat(i, 4);
    end
    @(negedge clk);
    hit_thr0 = '0; hit_thr1 = '0;
    expect_silence("R1 no frames without acquisition");

    // R1 R3 R5 sparse hits, start request during the window
    acquire(30, 0, 8'h5A, 6);
    check(exp_n == 10, "R1 model frame count", exp_n, 10);
    readout(0);
    expect_silence("R6 second request sends nothing");

    // R3 new window restarts numbering, R7 slow consumer
    acquire(25, 1, 8'hC3, -1);
    readout(1);

    // R4 overfill, frames past capacity dropped
    acquire(140, 1, 8'h81, -1);
    check(exp_n == 128, "R4 model capacity", exp_n, 128);
    readout(2);
    expect_silence("R8 empty after full readout");

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule